// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Decode

This block is the front end of a small 8-bit register machine with four general-purpose registers. It reads the program one byte per cycle from a ROM port with a combinational read, addressed by a 16-bit program counter. It classifies each leading byte into one of three register-operand formats and gathers the 0 to 3 immediate bytes that follow it. It then presents one complete decoded record to an execute stage over a valid/ready handshake.

Formats are told apart by the low nibble of the leading byte. Values 0 to 7 give the two-register format, 8 to 14 the single-register format, and 15 the format with no register field. Every format uses the same bit positions for its register fields. The number of immediate bytes is a fixed function of the decoded opcode. The execute stage redirects the stream with a jump-load input. The block performs no execution of its own.

Top module: `byte_insn_decoder`

## Requirements
- R1: During and directly after synchronous active-low reset, `dec_valid` is 0 and `rom_addr` equals the reset address (default 0).
- R2: The format code `dec_fmt` is 0 when the low nibble (bits 3:0) of the leading byte is 0..7, 1 when it is 8..14, and 2 when it is 15.
- R3: Format 0: `dec_opcode` = bits 3:0 zero-extended, `dec_dst` = bits 5:4, `dec_src` = bits 7:6.
- R4: Format 1: `dec_opcode` = {2'b00, bits 7:6, bits 3:0}, `dec_dst` = bits 5:4, `dec_src` = 0.
- R5: Format 2: `dec_opcode` = the whole byte, and `dec_dst` and `dec_src` are 0. Upper nibble values 0..8 are legal.
- R6: Immediate count: format 0 takes 1 byte when its opcode is 7, else 0. Format 1 takes 1 byte when the low nibble is 13, the value of bits 7:6 when it is 14, else 0. Format 2 takes 0 bytes for upper nibble 0..3, 2 bytes for 4..5, 1 byte for 6..7 and 3 bytes for 8.
- R7: `dec_len` = 1 + immediate count. The first immediate byte lands in `dec_imm[7:0]`, the second in [15:8] and the third in [23:16]. Bits with no byte behind them read 0.
- R8: A format-2 byte whose upper nibble is 9..15 sets `dec_illegal`, takes no immediates and gives `dec_len` = 1.
- R9: The program counter steps by exactly one for each byte taken. With `dec_ready` high, an instruction of length L is presented L cycles after the cycle in which its leading byte is on `rom_data`.
- R10: While `dec_valid` is high and `dec_ready` is low, the record does not change. The next instruction's final byte is not taken, so `rom_addr` stalls. When `dec_ready` rises, a waiting one-byte instruction is presented in the very next cycle.
- R11: `jmp_load` has priority over everything. In the next cycle `rom_addr` equals `jmp_addr`, any partly gathered instruction is dropped, and any presented record is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rom_addr | output | 16 | Program counter driving the ROM address |
| rom_data | input | 8 | ROM byte at `rom_addr`, same cycle |
| jmp_load | input | 1 | Load `jmp_addr` into the program counter and flush |
| jmp_addr | input | 16 | Jump target |
| dec_valid | output | 1 | Decoded record available |
| dec_ready | input | 1 | Execute stage accepts the record |
| dec_fmt | output | 2 | Format: 0 two-register, 1 one-register, 2 no-register |
| dec_opcode | output | 8 | Opcode, arranged per format |
| dec_dst | output | 2 | Destination register index |
| dec_src | output | 2 | Source register index |
| dec_imm | output | 24 | Immediate bytes, first byte in the low bits |
| dec_len | output | 3 | Instruction length in bytes, 1..4 |
| dec_illegal | output | 1 | Leading byte names no defined operation |

## Verification
The hardest case to reach from the ports is a redirect that arrives while immediate bytes are partly gathered and the output slot is either full or just freeing. The bench places a four-byte instruction in the ROM image and jumps onto it. It counts clock edges so that the second jump lands while two immediates are still owed. It then checks that nothing from the abandoned bytes appears. A separate scenario holds `dec_ready` low so a record is pending, then jumps, to show that the held record is withdrawn rather than delivered.

// File: rtl/ifd_pkg.sv
// Shared constants and record types for the byte-stream instruction decoder.
// Assumes byte-wide instructions with 2-bit register fields and at most
// three trailing immediate bytes.
package ifd_pkg;
    localparam int BYTE_W  = 8;
    localparam int REG_W   = 2;
    localparam int IMM_MAX = 3;
    localparam int IMM_W   = IMM_MAX * BYTE_W;
    localparam int CNT_W   = $clog2(IMM_MAX + 1);
    localparam int LEN_W   = $clog2(IMM_MAX + 2);

    // Low-nibble boundaries between formats
    localparam logic [3:0] ONE_FIRST   = 4'd8;
    localparam logic [3:0] ZERO_SEL    = 4'd15;
    // Opcodes that carry immediates
    localparam logic [3:0] TWO_IMM_OP  = 4'd7;
    localparam logic [3:0] ONE_IMM1_OP = 4'd13;
    localparam logic [3:0] ONE_IMMV_OP = 4'd14;

    typedef enum logic [1:0] {
        FMT_TWO  = 2'd0,
        FMT_ONE  = 2'd1,
        FMT_ZERO = 2'd2
    } fmt_e;

    // Result of classifying a leading byte
    typedef struct packed {
        fmt_e              fmt;
        logic [BYTE_W-1:0] opcode;
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  src;
        logic [CNT_W-1:0]  nimm;
        logic              illegal;
    } lead_t;

    // Complete decoded instruction
    typedef struct packed {
        fmt_e              fmt;
        logic [BYTE_W-1:0] opcode;
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  src;
        logic [IMM_W-1:0]  imm;
        logic [LEN_W-1:0]  len;
        logic              illegal;
    } rec_t;
endpackage

// File: rtl/ifd_classify.sv
// Leading-byte classifier: purely combinational.
// Splits the byte into format, opcode, register fields and immediate count.
// Assumes the low nibble selects the format; unused fields are driven to 0.
module ifd_classify
    import ifd_pkg::*;
(
    input  logic [BYTE_W-1:0] lead_byte,
    output lead_t             info
);
    logic [3:0]       lo_nib;
    logic [3:0]       hi_nib;
    logic [REG_W-1:0] top_pair;

    assign lo_nib   = lead_byte[3:0];
    assign hi_nib   = lead_byte[7:4];
    assign top_pair = lead_byte[7:6];

    // Decode fields and immediate count from the leading byte
    always_comb begin
        info = '0;
        if (lo_nib < ONE_FIRST) begin
            info.fmt    = FMT_TWO;
            info.opcode = {4'b0000, lo_nib};
            info.dst    = lead_byte[5:4];
            info.src    = top_pair;
            info.nimm   = (lo_nib == TWO_IMM_OP) ? CNT_W'(1) : '0;
        end else if (lo_nib != ZERO_SEL) begin
            info.fmt    = FMT_ONE;
            info.opcode = {2'b00, top_pair, lo_nib};
            info.dst    = lead_byte[5:4];
            if (lo_nib == ONE_IMM1_OP)
                info.nimm = CNT_W'(1);
            else if (lo_nib == ONE_IMMV_OP)
                info.nimm = CNT_W'(top_pair);
            else
                info.nimm = '0;
        end else begin
            info.fmt    = FMT_ZERO;
            info.opcode = lead_byte;
            unique case (hi_nib)
                4'd0, 4'd1, 4'd2, 4'd3: info.nimm = '0;
                4'd4, 4'd5:             info.nimm = CNT_W'(2);
                4'd6, 4'd7:             info.nimm = CNT_W'(1);
                4'd8:                   info.nimm = CNT_W'(3);
                default:                info.illegal = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/ifd_pc.sv
// Program counter: loads a jump target or steps by one per byte taken.
// Assumes load and step are never both needed; load wins.
module ifd_pc #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] pc
);
    // Hold, step or reload the counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= RESET_PC;
        else if (load)
            pc <= load_addr;
        else if (step)
            pc <= pc + ADDR_W'(1);
    end
endmodule

// File: rtl/ifd_hold.sv
// Output slot: holds one decoded record under a valid/ready handshake.
// Assumes load is only raised when slot_free is high.
module ifd_hold
    import ifd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic load,
    input  rec_t load_rec,
    input  logic ready,
    output logic valid,
    output rec_t rec,
    output logic slot_free
);
    assign slot_free = !valid || ready;

    // Track whether the slot is occupied
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid <= 1'b0;
        else if (flush)
            valid <= 1'b0;
        else if (load)
            valid <= 1'b1;
        else if (ready)
            valid <= 1'b0;
    end

    // Capture a record when one completes
    always_ff @(posedge clk) begin
        if (!rst_n)
            rec <= '0;
        else if (load && !flush)
            rec <= load_rec;
    end
endmodule

// File: rtl/byte_insn_decoder.sv
// Variable-length instruction fetch and decode front end.
// Reads one byte per cycle from a combinational-read ROM, classifies the
// leading byte, gathers trailing immediates and hands a full record to the
// execute stage. Assumes rom_data reflects rom_addr in the same cycle.
module byte_insn_decoder
    import ifd_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [7:0]        rom_data,
    input  logic              jmp_load,
    input  logic [ADDR_W-1:0] jmp_addr,
    output logic              dec_valid,
    input  logic              dec_ready,
    output logic [1:0]        dec_fmt,
    output logic [7:0]        dec_opcode,
    output logic [1:0]        dec_dst,
    output logic [1:0]        dec_src,
    output logic [23:0]       dec_imm,
    output logic [2:0]        dec_len,
    output logic              dec_illegal
);
    typedef enum logic { PH_LEAD, PH_IMM } phase_e;

    phase_e           phase;
    rec_t             work;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] idx;

    lead_t            info;
    rec_t             lead_rec;
    rec_t             done_rec;
    rec_t             out_rec;
    logic [IMM_W-1:0] imm_merged;
    logic             finishing;
    logic             step;
    logic             done;
    logic             slot_free;
    logic [ADDR_W-1:0] pc;

    ifd_classify u_classify (
        .lead_byte (rom_data),
        .info      (info)
    );

    // Build the record a leading byte would produce on its own
    always_comb begin
        lead_rec         = '0;
        lead_rec.fmt     = info.fmt;
        lead_rec.opcode  = info.opcode;
        lead_rec.dst     = info.dst;
        lead_rec.src     = info.src;
        lead_rec.illegal = info.illegal;
        lead_rec.len     = LEN_W'(info.nimm) + LEN_W'(1);
    end

    // Insert the current ROM byte into the immediate lane it belongs to
    always_comb begin
        imm_merged = work.imm;
        for (int k = 0; k < IMM_MAX; k++) begin
            if (idx == CNT_W'(k))
                imm_merged[k*BYTE_W +: BYTE_W] = rom_data;
        end
    end

    // Decide whether this byte completes an instruction and may be taken
    always_comb begin
        finishing = (phase == PH_LEAD) ? (info.nimm == '0) : (remain == CNT_W'(1));
        step      = !jmp_load && (!finishing || slot_free);
        done      = step && finishing;
        if (phase == PH_LEAD) begin
            done_rec = lead_rec;
        end else begin
            done_rec     = work;
            done_rec.imm = imm_merged;
        end
    end

    // Sequence leading byte then immediates, flushing on a jump
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_LEAD;
            remain <= '0;
            idx    <= '0;
            work   <= '0;
        end else if (jmp_load) begin
            phase  <= PH_LEAD;
            remain <= '0;
            idx    <= '0;
        end else if (step) begin
            if (phase == PH_LEAD) begin
                if (info.nimm != '0) begin
                    work   <= lead_rec;
                    remain <= info.nimm;
                    idx    <= '0;
                    phase  <= PH_IMM;
                end
            end else begin
                work.imm <= imm_merged;
                remain   <= remain - CNT_W'(1);
                idx      <= idx + CNT_W'(1);
                if (remain == CNT_W'(1))
                    phase <= PH_LEAD;
            end
        end
    end

    ifd_pc #(
        .ADDR_W   (ADDR_W),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (jmp_load),
        .load_addr (jmp_addr),
        .step      (step),
        .pc        (pc)
    );

    ifd_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (jmp_load),
        .load      (done),
        .load_rec  (done_rec),
        .ready     (dec_ready),
        .valid     (dec_valid),
        .rec       (out_rec),
        .slot_free (slot_free)
    );

    assign rom_addr    = pc;
    assign dec_fmt     = out_rec.fmt;
    assign dec_opcode  = out_rec.opcode;
    assign dec_dst     = out_rec.dst;
    assign dec_src     = out_rec.src;
    assign dec_imm     = out_rec.imm;
    assign dec_len     = out_rec.len;
    assign dec_illegal = out_rec.illegal;
endmodule

// File: rtl/byte_insn_decoder_checker.sv
// Property checker for byte_insn_decoder, attached by bind.
// Observes only the top-level ports.
module byte_insn_decoder_checker #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              jmp_load,
    input logic [ADDR_W-1:0] jmp_addr,
    input logic              dec_valid,
    input logic              dec_ready,
    input logic [1:0]        dec_fmt,
    input logic [7:0]        dec_opcode,
    input logic [1:0]        dec_dst,
    input logic [1:0]        dec_src,
    input logic [23:0]       dec_imm,
    input logic [2:0]        dec_len,
    input logic              dec_illegal
);
    logic rst_q;

    // Remember last cycle's reset level to spot the release
    always_ff @(posedge clk) rst_q <= rst_n;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_q) |-> (!dec_valid && rom_addr == RESET_PC));

    assert_zero_fmt_regs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_fmt == 2'd2) |-> (dec_dst == 2'd0 && dec_src == 2'd0));

    assert_len_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_len >= 3'd1 && dec_len <= 3'd4));

    assert_illegal_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_illegal) |-> (dec_len == 3'd1 && dec_fmt == 2'd2 && dec_imm == 24'd0));

    assert_pc_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !jmp_load |=> (rom_addr == $past(rom_addr) || rom_addr == ADDR_W'($past(rom_addr) + 1)));

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ready && !jmp_load) |=>
            (dec_valid && $stable(dec_fmt) && $stable(dec_opcode) && $stable(dec_dst)
             && $stable(dec_src) && $stable(dec_imm) && $stable(dec_len) && $stable(dec_illegal)));

    assert_jump_redirect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_load |=> (rom_addr == $past(jmp_addr) && !dec_valid));
endmodule

bind byte_insn_decoder byte_insn_decoder_checker #(
    .ADDR_W   (ADDR_W),
    .RESET_PC (RESET_PC)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rom_addr    (rom_addr),
    .jmp_load    (jmp_load),
    .jmp_addr    (jmp_addr),
    .dec_valid   (dec_valid),
    .dec_ready   (dec_ready),
    .dec_fmt     (dec_fmt),
    .dec_opcode  (dec_opcode),
    .dec_dst     (dec_dst),
    .dec_src     (dec_src),
    .dec_imm     (dec_imm),
    .dec_len     (dec_len),
    .dec_illegal (dec_illegal)
);

// File: tb/byte_insn_decoder_bench.sv
// Directed bench for byte_insn_decoder: one task per scenario.
module byte_insn_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] rom_addr;
    logic [7:0]  rom_data;
    logic        jmp_load;
    logic [15:0] jmp_addr;
    logic        dec_valid;
    logic        dec_ready;
    logic [1:0]  dec_fmt;
    logic [7:0]  dec_opcode;
    logic [1:0]  dec_dst;
    logic [1:0]  dec_src;
    logic [23:0] dec_imm;
    logic [2:0]  dec_len;
    logic        dec_illegal;

    logic [7:0] rom [0:255];
    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;
    assign rom_data = rom[rom_addr[7:0]];

    byte_insn_decoder u_byte_insn_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .rom_addr    (rom_addr),
        .rom_data    (rom_data),
        .jmp_load    (jmp_load),
        .jmp_addr    (jmp_addr),
        .dec_valid   (dec_valid),
        .dec_ready   (dec_ready),
        .dec_fmt     (dec_fmt),
        .dec_opcode  (dec_opcode),
        .dec_dst     (dec_dst),
        .dec_src     (dec_src),
        .dec_imm     (dec_imm),
        .dec_len     (dec_len),
        .dec_illegal (dec_illegal)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; redirects the program counter
    task automatic jump_to(input logic [15:0] addr);
        jmp_load = 1'b1;
        jmp_addr = addr;
        @(negedge clk);
        jmp_load = 1'b0;
    endtask

    // Wait for a record, returning the number of edges it took
    task automatic wait_rec(output int n);
        n = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end while (!dec_valid && n < 10);
    endtask

    task automatic expect_rec(input string req, input logic [1:0] fmt,
                              input logic [7:0] opc, input logic [1:0] dst,
                              input logic [1:0] src, input logic [23:0] imm,
                              input logic [2:0] len, input logic ill);
        check(req, "valid",   32'(dec_valid),   32'd1);
        check(req, "fmt",     32'(dec_fmt),     32'(fmt));
        check(req, "opcode",  32'(dec_opcode),  32'(opc));
        check(req, "dst",     32'(dec_dst),     32'(dst));
        check(req, "src",     32'(dec_src),     32'(src));
        check(req, "imm",     32'(dec_imm),     32'(imm));
        check(req, "len",     32'(dec_len),     32'(len));
        check(req, "illegal", 32'(dec_illegal), 32'(ill));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        dec_ready = 1'b0;
        jmp_load = 1'b0;
        jmp_addr = '0;
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", 32'(dec_valid), 32'd0);
        rst_n = 1'b1;
        check("R1", "valid after reset", 32'(dec_valid), 32'd0);
        check("R1", "rom_addr after reset", 32'(rom_addr), 32'h0);
    endtask

    task automatic t_two_reg;
        int n;
        rom[8'h10] = 8'hB2;
        rom[8'h11] = 8'h47; rom[8'h12] = 8'h5A;
        dec_ready = 1'b1;
        jump_to(16'h0010);
        wait_rec(n);
        check("R9", "edges for 1-byte", 32'(n), 32'd1);
        expect_rec("R2 R3", 2'd0, 8'h02, 2'd3, 2'd2, 24'h0, 3'd1, 1'b0);
        wait_rec(n);
        check("R9", "edges for 2-byte", 32'(n), 32'd2);
        expect_rec("R3 R6 R7", 2'd0, 8'h07, 2'd0, 2'd1, 24'h00005A, 3'd2, 1'b0);
        check("R9", "rom_addr after 2-byte", 32'(rom_addr), 32'h13);
    endtask

    task automatic t_one_reg;
        int n;
        rom[8'h20] = 8'hDA;
        rom[8'h21] = 8'hEE; rom[8'h22] = 8'h11; rom[8'h23] = 8'h22; rom[8'h24] = 8'h33;
        rom[8'h25] = 8'h1D; rom[8'h26] = 8'h7E;
        rom[8'h27] = 8'h0E;
        dec_ready = 1'b1;
        jump_to(16'h0020);
        wait_rec(n);
        expect_rec("R2 R4", 2'd1, 8'h3A, 2'd1, 2'd0, 24'h0, 3'd1, 1'b0);
        wait_rec(n);
        check("R9", "edges for 4-byte", 32'(n), 32'd4);
        expect_rec("R4 R6 R7", 2'd1, 8'h3E, 2'd2, 2'd0, 24'h332211, 3'd4, 1'b0);
        wait_rec(n);
        expect_rec("R6 R7", 2'd1, 8'h0D, 2'd1, 2'd0, 24'h00007E, 3'd2, 1'b0);
        wait_rec(n);
        expect_rec("R6", 2'd1, 8'h0E, 2'd0, 2'd0, 24'h0, 3'd1, 1'b0);
    endtask

    task automatic t_no_reg;
        int n;
        rom[8'h30] = 8'h3F;
        rom[8'h31] = 8'h4F; rom[8'h32] = 8'hCD; rom[8'h33] = 8'hAB;
        rom[8'h34] = 8'h6F; rom[8'h35] = 8'h99;
        rom[8'h36] = 8'h8F; rom[8'h37] = 8'h01; rom[8'h38] = 8'h02; rom[8'h39] = 8'h03;
        rom[8'h3A] = 8'h9F;
        rom[8'h3B] = 8'hFF;
        dec_ready = 1'b1;
        jump_to(16'h0030);
        wait_rec(n);
        expect_rec("R2 R5", 2'd2, 8'h3F, 2'd0, 2'd0, 24'h0, 3'd1, 1'b0);
        wait_rec(n);
        expect_rec("R5 R6 R7", 2'd2, 8'h4F, 2'd0, 2'd0, 24'h00ABCD, 3'd3, 1'b0);
        wait_rec(n);
        expect_rec("R6 R7", 2'd2, 8'h6F, 2'd0, 2'd0, 24'h000099, 3'd2, 1'b0);
        wait_rec(n);
        expect_rec("R6 R7", 2'd2, 8'h8F, 2'd0, 2'd0, 24'h030201, 3'd4, 1'b0);
        wait_rec(n);
        check("R8", "edges for illegal", 32'(n), 32'd1);
        expect_rec("R8", 2'd2, 8'h9F, 2'd0, 2'd0, 24'h0, 3'd1, 1'b1);
        wait_rec(n);
        expect_rec("R8", 2'd2, 8'hFF, 2'd0, 2'd0, 24'h0, 3'd1, 1'b1);
        check("R8", "rom_addr after illegal", 32'(rom_addr), 32'h3C);
    endtask

    task automatic t_backpressure;
        int n;
        rom[8'h50] = 8'hB2;
        rom[8'h51] = 8'hDA;
        dec_ready = 1'b0;
        jump_to(16'h0050);
        wait_rec(n);
        expect_rec("R10", 2'd0, 8'h02, 2'd3, 2'd2, 24'h0, 3'd1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R10", "held valid", 32'(dec_valid), 32'd1);
            check("R10", "held opcode", 32'(dec_opcode), 32'h02);
            check("R10", "held dst", 32'(dec_dst), 32'd3);
            check("R10", "stalled rom_addr", 32'(rom_addr), 32'h51);
        end
        dec_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        expect_rec("R10", 2'd1, 8'h3A, 2'd1, 2'd0, 24'h0, 3'd1, 1'b0);
        check("R10", "rom_addr after release", 32'(rom_addr), 32'h52);
    endtask

    task automatic t_jump_partial;
        int n;
        rom[8'h60] = 8'h8F; rom[8'h61] = 8'hAA; rom[8'h62] = 8'hBB; rom[8'h63] = 8'hCC;
        rom[8'h70] = 8'h3F;
        dec_ready = 1'b1;
        jump_to(16'h0060);
        for (int i = 0; i < 2; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R11", "no record mid-gather", 32'(dec_valid), 32'd0);
        end
        check("R9", "rom_addr mid-gather", 32'(rom_addr), 32'h62);
        jump_to(16'h0070);
        check("R11", "valid after jump", 32'(dec_valid), 32'd0);
        check("R11", "rom_addr after jump", 32'(rom_addr), 32'h70);
        wait_rec(n);
        check("R11", "edges after jump", 32'(n), 32'd1);
        expect_rec("R11 R7", 2'd2, 8'h3F, 2'd0, 2'd0, 24'h0, 3'd1, 1'b0);
    endtask

    task automatic t_jump_flush_held;
        int n;
        rom[8'h80] = 8'hB2;
        rom[8'h90] = 8'hDA;
        dec_ready = 1'b0;
        jump_to(16'h0080);
        wait_rec(n);
        check("R10", "held before jump", 32'(dec_valid), 32'd1);
        jump_to(16'h0090);
        check("R11", "held record withdrawn", 32'(dec_valid), 32'd0);
        check("R11", "rom_addr after flush", 32'(rom_addr), 32'h90);
        wait_rec(n);
        expect_rec("R11", 2'd1, 8'h3A, 2'd1, 2'd0, 24'h0, 3'd1, 1'b0);
        dec_ready = 1'b1;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below 20000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        for (int a = 0; a < 256; a++) rom[a] = 8'h00;
        t_reset();
        t_two_reg();
        t_one_reg();
        t_no_reg();
        t_backpressure();
        t_jump_partial();
        t_jump_flush_held();
        finish_run();
    end
endmodule